// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous, strobe-addressed DRAM alive. It sits next to the access controller, which owns the memory bus. The two blocks share the bus through a request/grant pair. Whenever this block needs the bus, it raises a request. It drives the row strobe and both column-byte strobes only while the grant is held. It drives neither addresses nor data. The DRAM's own row counter supplies the row, and the data pins stay high-impedance during every refresh.

After reset the block waits a programmable power-up pause. It then runs a fixed number of wake-up cycles and raises `ready`. From that point it asks for one column-before-row refresh cycle per interval, which spreads the refreshes evenly over the retention period. In each cycle both column strobes fall first, the row strobe follows a set number of cycles later, both rise together, and a precharge gap follows.

Refresh ticks whose grant is held back are queued, up to a limit, and replayed back to back. If a tick arrives while the queue is already full, the retention period counts as broken. `ready` then drops and the full wake-up sequence runs again.

Top module: `drefSequencer`

## Requirements
- R1: While reset is asserted, `ready` and `refReq` are 0 and `rowStrobeN`, `colStrobeLoN`, `colStrobeHiN` are 1.
- R2: After reset is released, `refReq` first goes high between PAUSE_CYC and PAUSE_CYC+2 clock cycles later, and no strobe moves before that.
- R3: The strobes stay high whenever `refReq` is low. A strobe only falls after a cycle in which `refGnt` was high, so while the grant is withheld, no strobe moves.
- R4: In every refresh cycle, both column strobes are low for exactly SETUP_CYC cycles before the row strobe falls, and they are low when it falls.
- R5: The row strobe stays low for exactly ROWLOW_CYC cycles. Both column strobes stay low throughout and are high again in the cycle the row strobe rises.
- R6: Between two row pulses, the row strobe stays high for at least PRE_CYC cycles.
- R7: After the pause, exactly WAKE_CYCLES row pulses occur with `ready` low, and `ready` then rises.
- R8: Once `ready` is high and the grant is always given, exactly one refresh cycle occurs per INTERVAL_CYC cycles, with `ready` high.
- R9: Ticks that arrive while the grant is withheld are held, up to PEND_MAX. When the grant returns, each held tick produces one refresh cycle, and `ready` stays high.
- R10: A tick that arrives while PEND_MAX refreshes are already held drops `ready`. The held count is then discarded, and WAKE_CYCLES wake-up pulses run before `ready` rises again.
- R11: Asserting reset during operation restarts the whole sequence, including the pause and the wake-up cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| refGnt | input | 1 | Bus grant from the access controller |
| refReq | output | 1 | Bus request; held high for the whole refresh or wake-up cycle |
| rowStrobeN | output | 1 | Row strobe to the DRAM, active low |
| colStrobeLoN | output | 1 | Low-byte column strobe, active low |
| colStrobeHiN | output | 1 | High-byte column strobe, active low |
| ready | output | 1 | Memory initialised and retention intact |

## Verification
The hardest state to reach from the ports is the overrun. The held-refresh count is internal, so the bench can only reach the overrun by withholding the grant across an exact number of interval ticks. It also has to know the tick phase, which it learns from the rising edge of `ready`. The bench first withholds the grant for three ticks, which fills the queue without overflowing it, and counts the replayed cycles. It then withholds the grant for four ticks and expects `ready` to drop and a full wake-up run to follow. A monitor measures every strobe pulse and matches it against a queue of expected cycles, each tagged with the `ready` level at which it should occur.

// File: rtl/drefPkg.sv
package drefPkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_REQ,
    ST_LEAD,
    ST_LOW,
    ST_PRE,
    ST_RUN
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic pauseRun;
    logic tickRun;
    logic phaseClr;
    logic wakeInc;
    logic wakeClr;
    logic pendDec;
    logic pendClr;
    logic reqOn;
    logic colLow;
    logic rowLow;
  } seqStrobe_t;

endpackage

// File: rtl/drefDatapath.sv
module drefDatapath
  import drefPkg::*;
#(
  parameter int PAUSE_CYC    = 40000,
  parameter int INTERVAL_CYC = 3120,
  parameter int WAKE_CYCLES  = 8,
  parameter int PEND_MAX     = 4,
  parameter int PH_W         = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  seqStrobe_t      ctl,
  output logic            pauseDone,
  output logic            tick,
  output logic            pendFull,
  output logic            pendZero,
  output logic            wakeLast,
  output logic [PH_W-1:0] phaseCnt,
  output logic            refReq,
  output logic            rowStrobeN,
  output logic            colStrobeLoN,
  output logic            colStrobeHiN
);

  localparam int PAUSE_W = $clog2(PAUSE_CYC + 1);
  localparam int TICK_W  = $clog2(INTERVAL_CYC + 1);
  localparam int WAKE_W  = $clog2(WAKE_CYCLES + 1);
  localparam int PEND_W  = $clog2(PEND_MAX + 1);
  localparam logic [PAUSE_W-1:0] PAUSE_LAST = PAUSE_W'(PAUSE_CYC - 1);
  localparam logic [TICK_W-1:0]  TICK_LAST  = TICK_W'(INTERVAL_CYC - 1);
  localparam logic [WAKE_W-1:0]  WAKE_LAST  = WAKE_W'(WAKE_CYCLES - 1);
  localparam logic [PEND_W-1:0]  PEND_TOP   = PEND_W'(PEND_MAX);

  logic [PAUSE_W-1:0] pauseCnt;
  logic [TICK_W-1:0]  tickCnt;
  logic [WAKE_W-1:0]  wakeCnt;
  logic [PEND_W-1:0]  pendCnt;
  logic [1:0]         colN;

  assign pauseDone = (pauseCnt == PAUSE_LAST);
  assign tick      = ctl.tickRun && (tickCnt == TICK_LAST);
  assign pendFull  = (pendCnt == PEND_TOP);
  assign pendZero  = (pendCnt == '0);
  assign wakeLast  = (wakeCnt == WAKE_LAST);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pauseCnt <= '0;
    end else if (ctl.pauseRun && !pauseDone) begin
      pauseCnt <= pauseCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      tickCnt <= '0;
    end else if (!ctl.tickRun || tickCnt == TICK_LAST) begin
      tickCnt <= '0;
    end else begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pendCnt <= '0;
    end else if (ctl.pendClr) begin
      pendCnt <= '0;
    end else if (tick && !ctl.pendDec && !pendFull) begin
      pendCnt <= pendCnt + 1'b1;
    end else if (!tick && ctl.pendDec && !pendZero) begin
      pendCnt <= pendCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      wakeCnt <= '0;
    end else if (ctl.wakeClr) begin
      wakeCnt <= '0;
    end else if (ctl.wakeInc) begin
      wakeCnt <= wakeCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      phaseCnt <= '0;
    end else if (ctl.phaseClr) begin
      phaseCnt <= '0;
    end else begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  // registered pins: request and row strobe
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      refReq     <= 1'b0;
      rowStrobeN <= 1'b1;
    end else begin
      refReq     <= ctl.reqOn;
      rowStrobeN <= !ctl.rowLow;
    end
  end

  // one flop per byte lane of the column strobe
  for (genvar g = 0; g < 2; g++) begin : gColLane
    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        colN[g] <= 1'b1;
      end else begin
        colN[g] <= !ctl.colLow;
      end
    end
  end

  assign colStrobeLoN = colN[0];
  assign colStrobeHiN = colN[1];

  AST_PEND_BOUND: assert property (@(posedge clk) disable iff (rst)
    pendCnt <= PEND_TOP); // R9
  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (rst)
    $fell(rowStrobeN) |-> ($past(colN) == 2'b00)); // R4
  AST_ROW_HAS_COL: assert property (@(posedge clk) disable iff (rst)
    !rowStrobeN |-> (colN == 2'b00)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !refReq |-> (rowStrobeN && colN == 2'b11)); // R3

endmodule

// File: rtl/drefControl.sv
module drefControl
  import drefPkg::*;
#(
  parameter int SETUP_CYC  = 2,
  parameter int ROWLOW_CYC = 10,
  parameter int PRE_CYC    = 8,
  parameter int PH_W       = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            refGnt,
  input  logic            pauseDone,
  input  logic            tick,
  input  logic            pendFull,
  input  logic            pendZero,
  input  logic            wakeLast,
  input  logic [PH_W-1:0] phaseCnt,
  output seqStrobe_t      ctl,
  output logic            ready
);

  localparam logic [PH_W-1:0] LEAD_LAST = PH_W'(SETUP_CYC - 1);
  localparam logic [PH_W-1:0] LOW_LAST  = PH_W'(ROWLOW_CYC - 1);
  localparam logic [PH_W-1:0] PRE_LAST  = PH_W'(PRE_CYC - 1);

  seqState_t state, nextState;
  logic      phaseEnd;
  logic      cycleEnd;
  logic      overrun;
  logic      readyNext;

  always_comb begin
    unique case (state)
      ST_LEAD: phaseEnd = (phaseCnt == LEAD_LAST);
      ST_LOW:  phaseEnd = (phaseCnt == LOW_LAST);
      ST_PRE:  phaseEnd = (phaseCnt == PRE_LAST);
      default: phaseEnd = 1'b0;
    endcase
  end

  assign cycleEnd = (state == ST_PRE) && phaseEnd;
  assign overrun  = ready && tick && pendFull;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_PAUSE: if (pauseDone) nextState = ST_REQ;
      ST_REQ:   if (refGnt) nextState = ST_LEAD;
      ST_LEAD:  if (phaseEnd) nextState = ST_LOW;
      ST_LOW:   if (phaseEnd) nextState = ST_PRE;
      ST_PRE: begin
        if (phaseEnd) nextState = (ready || wakeLast) ? ST_RUN : ST_REQ;
      end
      ST_RUN:   if (!ready || !pendZero) nextState = ST_REQ;
      default:  nextState = ST_PAUSE;
    endcase
  end

  always_comb begin
    readyNext = ready;
    if (overrun) readyNext = 1'b0;
    else if (cycleEnd && !ready && wakeLast) readyNext = 1'b1;
  end

  always_comb begin
    ctl.pauseRun = (state == ST_PAUSE);
    ctl.tickRun  = ready;
    ctl.phaseClr = (nextState != state);
    ctl.wakeInc  = cycleEnd && !ready;
    ctl.wakeClr  = overrun || (cycleEnd && !ready && wakeLast);
    ctl.pendDec  = cycleEnd && ready;
    ctl.pendClr  = overrun;
    ctl.reqOn    = (state == ST_REQ) || (state == ST_LEAD) ||
                   (state == ST_LOW) || (state == ST_PRE);
    ctl.colLow   = (state == ST_LEAD) || (state == ST_LOW);
    ctl.rowLow   = (state == ST_LOW);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state <= ST_PAUSE;
      ready <= 1'b0;
    end else begin
      state <= nextState;
      ready <= readyNext;
    end
  end

  AST_PAUSE_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PAUSE) |-> !ready); // R2
  AST_READY_AFTER_CYCLE: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (state == ST_RUN)); // R7
  AST_OVERRUN_DROPS: assert property (@(posedge clk) disable iff (rst)
    (ready && tick && pendFull) |=> !ready); // R10

endmodule

// File: rtl/drefSequencer.sv
module drefSequencer
  import drefPkg::*;
#(
  parameter int PAUSE_CYC    = 40000,
  parameter int INTERVAL_CYC = 3120,
  parameter int SETUP_CYC    = 2,
  parameter int ROWLOW_CYC   = 10,
  parameter int PRE_CYC      = 8,
  parameter int WAKE_CYCLES  = 8,
  parameter int PEND_MAX     = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic refGnt,
  output logic refReq,
  output logic rowStrobeN,
  output logic colStrobeLoN,
  output logic colStrobeHiN,
  output logic ready
);

  localparam int PH_MAX1 = (SETUP_CYC > ROWLOW_CYC) ? SETUP_CYC : ROWLOW_CYC;
  localparam int PH_MAX  = (PH_MAX1 > PRE_CYC) ? PH_MAX1 : PRE_CYC;
  localparam int PH_W    = $clog2(PH_MAX + 1);

  seqStrobe_t      ctl;
  logic            pauseDone, tick, pendFull, pendZero, wakeLast;
  logic [PH_W-1:0] phaseCnt;

  drefControl #(
    .SETUP_CYC (SETUP_CYC),
    .ROWLOW_CYC(ROWLOW_CYC),
    .PRE_CYC   (PRE_CYC),
    .PH_W      (PH_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .refGnt   (refGnt),
    .pauseDone(pauseDone),
    .tick     (tick),
    .pendFull (pendFull),
    .pendZero (pendZero),
    .wakeLast (wakeLast),
    .phaseCnt (phaseCnt),
    .ctl      (ctl),
    .ready    (ready)
  );

  drefDatapath #(
    .PAUSE_CYC   (PAUSE_CYC),
    .INTERVAL_CYC(INTERVAL_CYC),
    .WAKE_CYCLES (WAKE_CYCLES),
    .PEND_MAX    (PEND_MAX),
    .PH_W        (PH_W)
  ) u_path (
    .clk         (clk),
    .rst         (rst),
    .ctl         (ctl),
    .pauseDone   (pauseDone),
    .tick        (tick),
    .pendFull    (pendFull),
    .pendZero    (pendZero),
    .wakeLast    (wakeLast),
    .phaseCnt    (phaseCnt),
    .refReq      (refReq),
    .rowStrobeN  (rowStrobeN),
    .colStrobeLoN(colStrobeLoN),
    .colStrobeHiN(colStrobeHiN)
  );

  AST_STROBE_GRANTED: assert property (@(posedge clk) disable iff (rst)
    $fell(colStrobeLoN) |-> $past(refGnt)); // R3

endmodule

// File: tb/drefSequencer_tb.sv
module drefSequencer_tb;

  localparam int PAUSE    = 60;
  localparam int INTERVAL = 50;
  localparam int SETUP    = 2;
  localparam int ROWLOW   = 5;
  localparam int PRE      = 4;
  localparam int WAKE     = 8;
  localparam int PMAX     = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic refGnt = 1'b0;
  logic refReq, rowStrobeN, colStrobeLoN, colStrobeHiN, ready;

  always #2.5 clk = ~clk;

  drefSequencer #(
    .PAUSE_CYC(PAUSE), .INTERVAL_CYC(INTERVAL), .SETUP_CYC(SETUP),
    .ROWLOW_CYC(ROWLOW), .PRE_CYC(PRE), .WAKE_CYCLES(WAKE), .PEND_MAX(PMAX)
  ) u_dut (
    .clk(clk), .rst(rst), .refGnt(refGnt), .refReq(refReq),
    .rowStrobeN(rowStrobeN), .colStrobeLoN(colStrobeLoN),
    .colStrobeHiN(colStrobeHiN), .ready(ready)
  );

  int  compared = 0;
  int  mismatched = 0;
  bit  finished = 0;
  bit  gntAllow = 1;
  bit  expQ[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pushExp(input int n, input bit rdy);
    for (int i = 0; i < n; i++) expQ.push_back(rdy);
  endtask

  task automatic waitReady(input string tag);
    int n = 0;
    while (!ready && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(ready == 1'b1, tag, ready, 1);
  endtask

  // grant model
  always @(negedge clk) refGnt <= gntAllow && refReq;

  // monitor: measure each row pulse and pop the expected entry
  logic prevRow = 1'b1;
  int   leadCnt = 0, lowCnt = 0, highCnt = 0, curLead = 0;
  bit   curRdy = 0, seen = 0;
  always @(negedge clk) begin
    if (rst) begin
      prevRow = 1'b1; leadCnt = 0; lowCnt = 0; highCnt = 0; seen = 0;
    end else begin
      if (!rowStrobeN && prevRow) begin
        check(!seen || highCnt >= PRE, "R6 precharge", highCnt, PRE);
        check(!colStrobeLoN && !colStrobeHiN, "R4 col low at row fall",
              {colStrobeHiN, colStrobeLoN}, 0);
        curLead = leadCnt; curRdy = ready; lowCnt = 1;
      end else if (!rowStrobeN) begin
        lowCnt++;
      end else if (!prevRow) begin
        check(colStrobeLoN && colStrobeHiN, "R5 col rise with row",
              {colStrobeHiN, colStrobeLoN}, 3);
        seen = 1; highCnt = 1; leadCnt = 0;
        if (expQ.size() == 0) begin
          check(1'b0, "R8 unexpected pulse", 1, 0);
        end else begin
          bit e;
          e = expQ.pop_front();
          check(curRdy == e, "R7/R8 ready level at pulse", curRdy, e);
          check(curLead == SETUP, "R4 col lead", curLead, SETUP);
          check(lowCnt == ROWLOW, "R5 row low width", lowCnt, ROWLOW);
        end
      end else begin
        highCnt++;
        if (!colStrobeLoN && !colStrobeHiN) leadCnt++;
        else leadCnt = 0;
      end
      prevRow = rowStrobeN;
    end
  end

  task automatic resetCheck();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check(!ready && !refReq, "R1 ready/req in reset", {ready, refReq}, 0);
    check(rowStrobeN && colStrobeLoN && colStrobeHiN, "R1 strobes in reset",
          {rowStrobeN, colStrobeLoN, colStrobeHiN}, 7);
  endtask

  task automatic startUp(input string tag);
    int n = 0;
    pushExp(WAKE, 1'b0);
    rst = 1'b0;
    while (!refReq && n < 1000) begin
      @(negedge clk);
      n++;
    end
    check(n >= PAUSE && n <= PAUSE + 2, tag, n, PAUSE + 1);
    waitReady("R7 ready after wake");
    check(expQ.size() == 0, "R7 wake pulse count", expQ.size(), 0);
  endtask

  initial begin
    bit quiet;
    resetCheck();
    startUp("R2 pause length");

    // R8: steady rate, three intervals
    pushExp(3, 1'b1);
    repeat (3 * INTERVAL + 20) @(negedge clk);
    check(expQ.size() == 0, "R8 one refresh per interval", expQ.size(), 0);

    // R3/R9: withhold grant across three ticks
    gntAllow = 0;
    quiet = 1;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (!rowStrobeN || !colStrobeLoN || !colStrobeHiN) quiet = 0;
    end
    check(quiet, "R3 no strobe without grant", quiet, 1);
    check(refReq == 1'b1, "R9 request held while pending", refReq, 1);
    pushExp(4, 1'b1);
    gntAllow = 1;
    repeat (75) @(negedge clk);
    check(expQ.size() == 0, "R9 held ticks replayed", expQ.size(), 0);
    check(ready == 1'b1, "R9 ready kept", ready, 1);

    // R10: withhold across four ticks -> overrun
    gntAllow = 0;
    repeat (165) @(negedge clk);
    check(ready == 1'b0, "R10 ready dropped on overrun", ready, 0);
    pushExp(WAKE, 1'b0);
    gntAllow = 1;
    waitReady("R10 ready after re-wake");
    check(expQ.size() == 0, "R10 re-wake pulse count", expQ.size(), 0);

    // R11: reset during operation
    repeat (5) @(negedge clk);
    resetCheck();
    startUp("R11 pause after second reset");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule